// File: doc/BRIEF.md
# Multi-mode 7:1 pixel serializer

The block takes one parallel pixel per pixel period: red, green and blue at up to ten bits each, plus horizontal sync, vertical sync and data enable. It serializes the pixel onto up to five data lanes and one clock lane, using seven bit slots per pixel period. It runs from a fast clock together with a bit-rate enable, `bitEn`, which pulses seven times per pixel period. Each pulse moves all lanes on to the next slot.

A mode input selects one of five mappings from colour bits to slots. The mappings are an 18-bit layout, two 24-bit layouts and two 30-bit layouts. The two 24-bit layouts differ in which bits go on the extra lane: one puts the least significant colour bits there, the other the most significant. The two 30-bit layouts differ in the same way. The mode also sets how many lanes are in use. The pixel and the mode are both captured at the start of each period, so the input may change freely while a word is being sent.

Top module: `pix_serializer`

## Requirements
- R1: After reset the slot index rests at 6. Each cycle with `bitEn` high moves it to the next slot, 0,1,...,6, and from 6 back to 0. In cycles with `bitEn` low, every output keeps its value. The outputs show the new slot in the cycle after the enabled edge.
- R2: Across slots 0 to 6, `clkLane` is 1,1,0,0,0,1,1.
- R3: Lanes 0 to 2 use a base offset o, which is 0 in modes 0, 3 and 4, 2 in mode 1 and 4 in mode 2. The slots 0..6 carry:
  - lane 0: G[o], R[o+5], R[o+4], R[o+3], R[o+2], R[o+1], R[o]
  - lane 1: B[o+1], B[o], G[o+5], G[o+4], G[o+3], G[o+2], G[o+1]
  - lane 2: DE, VS, HS, B[o+5], B[o+4], B[o+3], B[o+2]
- R4: An extra lane with offset p carries, over slots 0..6: 0, B[p+1], B[p], G[p+1], G[p], R[p+1], R[p]. Lane 3 is such a lane with p=0 in mode 1, p=2 in mode 2, and p=6 in modes 3 and 4. Lane 4 is such a lane with p=0 in mode 2 and p=8 in mode 4.
- R5: The control signals are placed as follows. HS is on lane 2 slot 2, VS on lane 2 slot 1, and DE on lane 2 slot 0. In slot 0 of lanes 3 and 4 the output is always 0.
- R6: Lanes that the mode does not use are held at 0: lanes 3 and 4 in the 18-bit mode, and lane 4 in the 24-bit modes. Colour bits above the width of the mode have no effect on any lane.
- R7: The pixel inputs are sampled only at the enabled edge that starts slot 0. Input changes during slots 1 to 6 do not alter the word being sent.
- R8: The mode codes are 0 = 18-bit, 1 = 24-bit with the low bits on the extra lane, 2 = 30-bit with the low bits on the extra lanes, 3 = 24-bit with the high bits on the extra lane, and 4 = 30-bit with the high bits on the extra lanes. Codes 5 to 7 behave as code 0. The mode is sampled only at the start of slot 0.
- R9: During and just after reset, before the first enabled edge, `laneOut` is 0 and `clkLane` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Slot advance enable, seven pulses per pixel period |
| mode | input | 3 | Mapping select, sampled at the start of slot 0 |
| red | input | 10 | Red component, bit 0 is the least significant |
| green | input | 10 | Green component |
| blue | input | 10 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| dataEn | input | 1 | Data enable |
| laneOut | output | 5 | Serial data lanes, bit n is lane n |
| clkLane | output | 1 | Serial clock lane |

## Verification
The assertions assume that `bitEn` is a plain enable, which may be high in any cycle, and that `mode` may hold any 3-bit code, including the codes 5 to 7. They assume no fixed spacing between enable pulses. The stimulus never keeps `bitEn` high for two cycles in a row: it pulses the enable and then leaves idle cycles between pulses. During slots 1 to 6 it drives the pixel and the mode to unrelated values, which tests the claim that they are captured only at slot 0. The sweep walks a single one across every colour and control bit in each of the eight mode codes, and then adds pseudo-random pixels.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam int COLOR_W = 10;
  localparam int LANES   = 5;
  localparam int SLOTS   = 7;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int OFF_W   = $clog2(COLOR_W);
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [2:0] {
    MAP_18   = 3'd0,
    MAP_24LO = 3'd1,
    MAP_30LO = 3'd2,
    MAP_24HI = 3'd3,
    MAP_30HI = 3'd4
  } mapMode_e;

  typedef struct packed {
    logic              advance;
    logic              load;
    logic [SLOT_W-1:0] slot;
  } serCtrl_t;

  typedef struct packed {
    logic               de;
    logic               vs;
    logic               hs;
    logic [COLOR_W-1:0] b;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] r;
  } pixel_t;

  typedef struct packed {
    logic [OFF_W-1:0] coreOff;
    logic [OFF_W-1:0] ext3Off;
    logic [OFF_W-1:0] ext4Off;
    logic             ext3On;
    logic             ext4On;
  } mapCfg_t;

  function automatic mapCfg_t decodeMode(input logic [2:0] m);
    mapCfg_t c;
    c = '0;
    case (m)
      MAP_24LO: begin c.coreOff = 2; c.ext3Off = 0; c.ext3On = 1'b1; end
      MAP_30LO: begin
        c.coreOff = 4; c.ext3Off = 2; c.ext4Off = 0;
        c.ext3On = 1'b1; c.ext4On = 1'b1;
      end
      MAP_24HI: begin c.coreOff = 0; c.ext3Off = 6; c.ext3On = 1'b1; end
      MAP_30HI: begin
        c.coreOff = 0; c.ext3Off = 6; c.ext4Off = 8;
        c.ext3On = 1'b1; c.ext4On = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pix_ser_ctrl.sv
module pix_ser_ctrl
  import pix_ser_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitEn,
  output serCtrl_t ctrl
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slotQ;
  logic [SLOT_W-1:0] slotNext;

  assign slotNext = (slotQ == LAST_SLOT) ? '0 : SLOT_W'(slotQ + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= LAST_SLOT;
    else if (bitEn) slotQ <= slotNext;
  end

  always_comb begin
    ctrl.advance = bitEn;
    ctrl.load    = bitEn && (slotQ == LAST_SLOT);
    ctrl.slot    = slotQ;
  end
endmodule

// File: rtl/pix_ser_datapath.sv
module pix_ser_datapath
  import pix_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  serCtrl_t         ctrl,
  input  logic [2:0]       modeIn,
  input  pixel_t           pixIn,
  output logic [LANES-1:0] laneOut,
  output logic             clkLane,
  output logic [2:0]       modeOut
);
  pixel_t           holdQ;
  logic [2:0]       modeQ;
  mapCfg_t          cfg;
  logic [SLOTS-1:0] laneWord [LANES];
  logic [LANES-1:0] laneOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
      modeQ <= MAP_18;
    end else if (ctrl.load) begin
      holdQ <= pixIn;
      modeQ <= modeIn;
    end
  end

  assign cfg = decodeMode(modeQ);

  always_comb begin
    logic [OFF_W-1:0] o;
    o = cfg.coreOff;
    laneWord[0] = {holdQ.r[o], holdQ.r[o+1], holdQ.r[o+2], holdQ.r[o+3],
                   holdQ.r[o+4], holdQ.r[o+5], holdQ.g[o]};
    laneWord[1] = {holdQ.g[o+1], holdQ.g[o+2], holdQ.g[o+3], holdQ.g[o+4],
                   holdQ.g[o+5], holdQ.b[o], holdQ.b[o+1]};
    laneWord[2] = {holdQ.b[o+2], holdQ.b[o+3], holdQ.b[o+4], holdQ.b[o+5],
                   holdQ.hs, holdQ.vs, holdQ.de};
  end

  genvar e;
  generate
    for (e = 3; e < LANES; e++) begin : gExtra
      logic [OFF_W-1:0] p;
      assign p = (e == 3) ? cfg.ext3Off : cfg.ext4Off;
      assign laneWord[e] = {holdQ.r[p], holdQ.r[p+1], holdQ.g[p], holdQ.g[p+1],
                            holdQ.b[p], holdQ.b[p+1], 1'b0};
    end
  endgenerate

  assign laneOn = {cfg.ext4On, cfg.ext3On, 3'b111};

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : gLane
      assign laneOut[l] = laneOn[l] & laneWord[l][ctrl.slot];
    end
  endgenerate

  assign clkLane = CLK_PATTERN[ctrl.slot];
  assign modeOut = modeQ;
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEn,
  input  logic [2:0]          mode,
  input  logic [COLOR_W-1:0]  red,
  input  logic [COLOR_W-1:0]  green,
  input  logic [COLOR_W-1:0]  blue,
  input  logic                hsync,
  input  logic                vsync,
  input  logic                dataEn,
  output logic [LANES-1:0]    laneOut,
  output logic                clkLane
);
  serCtrl_t          ctrl;
  pixel_t            pixIn;
  logic [SLOT_W-1:0] curSlot;
  logic [2:0]        curMode;

  assign pixIn = '{de: dataEn, vs: vsync, hs: hsync, b: blue, g: green, r: red};

  pix_ser_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (bitEn),
    .ctrl  (ctrl)
  );

  pix_ser_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .modeIn  (mode),
    .pixIn   (pixIn),
    .laneOut (laneOut),
    .clkLane (clkLane),
    .modeOut (curMode)
  );

  assign curSlot = ctrl.slot;
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic [4:0] laneOut,
  input logic       clkLane,
  input logic [2:0] slotIdx,
  input logic [2:0] modeIdx
);
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    slotIdx <= 3'd6); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> slotIdx == (($past(slotIdx) == 3'd6) ? 3'd0 : $past(slotIdx) + 3'd1)); // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(laneOut) && $stable(clkLane))); // R1

  AST_CLK_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkLane) |-> slotIdx == 3'd2); // R2

  AST_CLK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkLane) |-> slotIdx == 3'd5); // R2

  AST_EXTRA_SLOT0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx == 3'd0) |-> laneOut[4:3] == 2'b00); // R5

  AST_NARROW_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    !(modeIdx inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> laneOut[4:3] == 2'b00); // R6

  AST_24_LANE4_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (modeIdx inside {3'd1, 3'd3}) |-> !laneOut[4]); // R6

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !(bitEn && slotIdx == 3'd6) |=> $stable(modeIdx)); // R8
endmodule

bind pix_serializer pix_serializer_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .bitEn   (bitEn),
  .laneOut (laneOut),
  .clkLane (clkLane),
  .slotIdx (curSlot),
  .modeIdx (curMode)
);

// File: tb/pix_serializer_tb_top.sv
module pix_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [9:0] red = '0, green = '0, blue = '0;
  logic       hsync = 1'b0, vsync = 1'b0, dataEn = 1'b0;
  logic [4:0] laneOut;
  logic       clkLane;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pix_serializer dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .mode(mode),
    .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .dataEn(dataEn),
    .laneOut(laneOut), .clkLane(clkLane)
  );

  // pixel vector: {de, vs, hs, b[9:0], g[9:0], r[9:0]}
  function automatic logic [34:0] expFrame(input int m, input logic [32:0] px);
    logic [9:0] r, g, b;
    logic hs, vs, de;
    logic [6:0] l0, l1, l2, l3, l4;
    r = px[9:0]; g = px[19:10]; b = px[29:20];
    hs = px[30]; vs = px[31]; de = px[32];
    l0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
    l1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
    l2 = {b[2], b[3], b[4], b[5], hs, vs, de};
    l3 = '0; l4 = '0;
    case (m)
      1: begin
        l0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
        l1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
        l2 = {b[4], b[5], b[6], b[7], hs, vs, de};
        l3 = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      end
      2: begin
        l0 = {r[4], r[5], r[6], r[7], r[8], r[9], g[4]};
        l1 = {g[5], g[6], g[7], g[8], g[9], b[4], b[5]};
        l2 = {b[6], b[7], b[8], b[9], hs, vs, de};
        l3 = {r[2], r[3], g[2], g[3], b[2], b[3], 1'b0};
        l4 = {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0};
      end
      3: l3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
      4: begin
        l3 = {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0};
        l4 = {r[8], r[9], g[8], g[9], b[8], b[9], 1'b0};
      end
      default: ;
    endcase
    return {l4, l3, l2, l1, l0};
  endfunction

  task automatic applyPix(input logic [32:0] px);
    red = px[9:0]; green = px[19:10]; blue = px[29:20];
    hsync = px[30]; vsync = px[31]; dataEn = px[32];
  endtask

  task automatic cmp(input string tag, input logic [4:0] got, input logic [4:0] exp,
                     input int m, input int s);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d slot=%0d actual=%b expected=%b", tag, m, s, got, exp);
    end
  endtask

  task automatic checkSlot(input int m, input int s, input logic [34:0] f);
    logic [4:0] e;
    logic [6:0] pat;
    pat = 7'b1100011;
    for (int l = 0; l < 5; l++) e[l] = f[l*7 + s];
    cmp("R1 R2 clock lane", {4'b0, clkLane}, {4'b0, pat[s]}, m, s);
    cmp("R3 R5 R7 lanes 0-2", {2'b0, laneOut[2:0]}, {2'b0, e[2:0]}, m, s);
    if (m >= 1 && m <= 4)
      cmp("R4 R5 R8 lanes 3-4", {3'b0, laneOut[4:3]}, {3'b0, e[4:3]}, m, s);
    else
      cmp("R6 R8 unused lanes", {3'b0, laneOut[4:3]}, 5'b0, m, s);
  endtask

  task automatic sendPixel(input int m, input logic [32:0] px);
    logic [34:0] f;
    f = expFrame(m, px);
    @(negedge clk);
    applyPix(px);
    mode = 3'(m);
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    checkSlot(m, 0, f);
    applyPix(~px);
    mode = 3'(m ^ 3);
    for (int s = 1; s < 7; s++) begin
      @(negedge clk);
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      checkSlot(m, s, f);
      if (s == 3) begin
        @(negedge clk);
        checkSlot(m, s, f);  // R1: idle cycle holds outputs
      end
    end
  endtask

  initial begin
    logic [32:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R9 reset lanes", laneOut, 5'b0, 0, 6);
    cmp("R9 reset clock", {4'b0, clkLane}, 5'b00001, 0, 6);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R9 post-reset lanes", laneOut, 5'b0, 0, 6);
    cmp("R9 post-reset clock", {4'b0, clkLane}, 5'b00001, 0, 6);
    lfsr = 33'h1_2345_6789;
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 33; b++) sendPixel(m, 33'(1) << b);
      sendPixel(m, '1);
      for (int k = 0; k < 6; k++) begin
        lfsr = {lfsr[31:0], lfsr[32] ^ lfsr[19]};
        lfsr = {lfsr[31:0], lfsr[32] ^ lfsr[19]} ^ 33'(k * 97 + m);
        sendPixel(m, lfsr);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      vectors++;
      $display("FAIL watchdog expired before the sweep completed");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule